// File: doc/BRIEF.md
# Dual Interval Timer Peripheral

This peripheral holds one or two independent 32-bit counters that software sets up and watches through a small word-addressed register bus. Each counter has three live registers: a control/status word, a load value and the running count. A control write with the run bit set restarts the counter from the load value. From there it steps once per clock, either down towards zero or up towards all-ones. The counter expires when it reaches that end value. On expiry it raises its event flag, and then it either restarts from the load value or halts, as its auto-restart bit selects.

Both counters drive one shared interrupt line. That line goes high when any present counter has its event flag set and its interrupt-enable bit set. A build-time parameter picks one or two counters. With one counter, the second register window reads as zero and ignores writes. Only full 32-bit word accesses are modelled, so the two lowest address bits are ignored. The block runs on the bus clock and has a synchronous active-low reset.

Top module: `dual_timer_periph`

## Requirements
- R1: While reset is low at a clock edge, every count, load and control register clears, both counters stop and the interrupt goes low. After reset, every register reads zero.
- R2: The load register (window word 1) reads back what was written. The control register (window word 0) stores only bits 10..0, and bits 31..11 read as zero. Writes to the count register (window word 2) are ignored.
- R3: Control bit 1 set means down-counting. A control write with bit 7 (run) set loads the count from the load register on that edge. In down mode the count then falls by one per clock. The counter expires, setting flag bit 8, on the edge where it already holds zero. A load of L therefore sets the flag L+1 edges after the write.
- R4: With control bit 1 clear, the count rises by one per clock from the load value. It expires on the edge where it holds all-ones, which is 2^32 - L edges after the write.
- R5: Control bit 4 (auto-restart) makes an expiring counter reload the load value and keep running. Without it, the counter halts and holds its end value.
- R6: A control write with bit 8 set clears the event flag. A control write with bit 8 clear leaves the flag unchanged.
- R7: If an expiry and a flag-clearing control write fall on the same edge, the flag ends up set.
- R8: The interrupt output is registered. It equals the OR, over the present counters, of (flag AND control bit 6), as those values stood one edge earlier. A counter with bit 6 clear never raises it.
- R9: The second counter's window starts at byte offset 0x10 and runs independently of the first.
- R10: Window word 3 reads zero and ignores writes. With one counter configured, every access to the 0x10 window reads zero and has no effect.
- R11: A control write with bit 7 clear stops the counter. The count keeps its value on that edge and in every later cycle, until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address; bit 4 picks the window, bits 3..2 pick the word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from the addressed register |
| irq_o | output | 1 | Shared registered interrupt |

## Verification
Down-mode loads are swept from 0 to 7 and up-mode loads from all-ones minus 7 to all-ones, with the count checked on every cycle. These sweeps separate an off-by-one in the terminal test from a wrong step direction. Auto-restart is run over several periods, and the stop write is checked for holding the count. A clear write is placed exactly on the expiry edge to tell the two flag priorities apart. Masked and unmasked flags on each window, plus a one-counter build, show whether the interrupt OR covers only the present, enabled counters.

// File: rtl/dtp_pkg.sv
// Shared constants for the dual interval timer.
// Assumes 32-bit word registers with four word slots per window.
package dtp_pkg;
    localparam int CTRL_W    = 11;
    localparam int NT_MAX    = 2;
    localparam int CB_MODE   = 0;
    localparam int CB_DOWN   = 1;
    localparam int CB_GEN    = 2;
    localparam int CB_CAPT   = 3;
    localparam int CB_RELOAD = 4;
    localparam int CB_LDBIT  = 5;
    localparam int CB_IE     = 6;
    localparam int CB_RUN    = 7;
    localparam int CB_FLAG   = 8;
    localparam int CB_PWM    = 9;
    localparam int CB_ALL    = 10;

    typedef enum logic [1:0] {
        W_CTRL  = 2'd0,
        W_LOAD  = 2'd1,
        W_COUNT = 2'd2,
        W_SPARE = 2'd3
    } word_e;
endpackage

// File: rtl/dtp_addr_decode.sv
// Address decoder: splits a byte address into a window index and a word slot,
// and produces per-counter write strobes. Assumes word-aligned 32-bit access;
// address bits above the window bit are not decoded.
module dtp_addr_decode
    import dtp_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int TIMER_COUNT = 2
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              win_o,
    output word_e             word_o,
    output logic              present_o,
    output logic [NT_MAX-1:0] wr_ctrl_o,
    output logic [NT_MAX-1:0] wr_load_o
);
    localparam int WORD_LSB = 2;
    localparam int WIN_BIT  = 4;

    // Split the address into window and word slot.
    always_comb begin
        win_o     = bus_addr[WIN_BIT];
        word_o    = word_e'(bus_addr[WORD_LSB+1:WORD_LSB]);
        present_o = (32'(win_o) < TIMER_COUNT);
    end

    // Per-window write strobes, suppressed for absent windows.
    always_comb begin
        wr_ctrl_o = '0;
        wr_load_o = '0;
        for (int i = 0; i < NT_MAX; i++) begin
            if (bus_en && bus_we && present_o && (32'(win_o) == i)) begin
                wr_ctrl_o[i] = (word_o == W_CTRL);
                wr_load_o[i] = (word_o == W_LOAD);
            end
        end
    end
endmodule

// File: rtl/dtp_timer_core.sv
// One interval counter: control word, load value, live count and run state.
// A control write takes priority over counting; expiry sets the flag even
// when a clearing write lands on the same edge.
module dtp_timer_core
    import dtp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] count_o,
    output logic              running_o,
    output logic              flag_o,
    output logic              irq_req_o
);
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [DATA_W-1:0] load_q, count_q, count_d;
    logic              run_q, run_d;
    logic              terminal, expire, flag_d;

    // Detect the end value for the current direction.
    always_comb begin
        terminal = ctrl_q[CB_DOWN] ? (count_q == '0) : (count_q == {DATA_W{1'b1}});
        expire   = run_q && terminal;
    end

    // Next flag and control word: expiry beats a clearing write.
    always_comb begin
        if (expire)
            flag_d = 1'b1;
        else if (wr_ctrl && wdata[CB_FLAG])
            flag_d = 1'b0;
        else
            flag_d = ctrl_q[CB_FLAG];
        ctrl_d = wr_ctrl ? wdata[CTRL_W-1:0] : ctrl_q;
        ctrl_d[CB_FLAG] = flag_d;
    end

    // Next count and run state.
    always_comb begin
        count_d = count_q;
        run_d   = run_q;
        if (wr_ctrl) begin
            run_d = wdata[CB_RUN];
            if (wdata[CB_RUN])
                count_d = load_q;
        end else if (expire) begin
            run_d = ctrl_q[CB_RELOAD];
            if (ctrl_q[CB_RELOAD])
                count_d = load_q;
        end else if (run_q) begin
            count_d = ctrl_q[CB_DOWN] ? count_q - 1'b1 : count_q + 1'b1;
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            load_q  <= '0;
            count_q <= '0;
            run_q   <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            count_q <= count_d;
            run_q   <= run_d;
            if (wr_load)
                load_q <= wdata;
        end
    end

    // Drive outputs.
    always_comb begin
        ctrl_o    = ctrl_q;
        load_o    = load_q;
        count_o   = count_q;
        running_o = run_q;
        flag_o    = ctrl_q[CB_FLAG];
        irq_req_o = ctrl_q[CB_FLAG] && ctrl_q[CB_IE];
    end
endmodule

// File: rtl/dtp_irq_combine.sv
// Registers the OR of per-counter interrupt requests onto one line.
// Assumes requests are already masked by their enables.
module dtp_irq_combine #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic         irq_o
);
    logic irq_q;

    // One register stage after the OR.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |req_i;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/dual_timer_periph.sv
// Top level: decoder, one or two counters, read mux and shared interrupt.
// Assumes full-word accesses only; reads are combinational.
module dual_timer_periph
    import dtp_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int TIMER_COUNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic              win;
    word_e             word;
    logic              present;
    logic [NT_MAX-1:0] wr_ctrl_v, wr_load_v;
    logic [NT_MAX-1:0] run_v, flag_v, req_v;
    logic [CTRL_W-1:0] ctrl_v  [NT_MAX];
    logic [DATA_W-1:0] load_v  [NT_MAX];
    logic [DATA_W-1:0] count_v [NT_MAX];

    dtp_addr_decode #(.ADDR_W(ADDR_W), .TIMER_COUNT(TIMER_COUNT)) u_dec (
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .win_o     (win),
        .word_o    (word),
        .present_o (present),
        .wr_ctrl_o (wr_ctrl_v),
        .wr_load_o (wr_load_v)
    );

    for (genvar g = 0; g < NT_MAX; g++) begin : g_tmr
        if (g < TIMER_COUNT) begin : g_on
            dtp_timer_core #(.DATA_W(DATA_W)) u_core (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_ctrl   (wr_ctrl_v[g]),
                .wr_load   (wr_load_v[g]),
                .wdata     (bus_wdata),
                .ctrl_o    (ctrl_v[g]),
                .load_o    (load_v[g]),
                .count_o   (count_v[g]),
                .running_o (run_v[g]),
                .flag_o    (flag_v[g]),
                .irq_req_o (req_v[g])
            );
        end else begin : g_off
            assign ctrl_v[g]  = '0;
            assign load_v[g]  = '0;
            assign count_v[g] = '0;
            assign run_v[g]   = 1'b0;
            assign flag_v[g]  = 1'b0;
            assign req_v[g]   = 1'b0;
        end
    end

    // Select read data from the addressed window and word.
    always_comb begin
        bus_rdata = '0;
        if (present) begin
            case (word)
                W_CTRL:  bus_rdata = DATA_W'(ctrl_v[32'(win)]);
                W_LOAD:  bus_rdata = load_v[32'(win)];
                W_COUNT: bus_rdata = count_v[32'(win)];
                default: bus_rdata = '0;
            endcase
        end
    end

    dtp_irq_combine #(.N(NT_MAX)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_v),
        .irq_o (irq_o)
    );
endmodule

// File: rtl/dtp_checker.sv
// Property checker for the dual interval timer, bound to the top level.
module dtp_checker
    import dtp_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int TIMER_COUNT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic [NT_MAX-1:0] wr_ctrl_v,
    input logic [NT_MAX-1:0] run_v,
    input logic [NT_MAX-1:0] flag_v,
    input logic [NT_MAX-1:0] ie_v,
    input logic [DATA_W-1:0] load0,
    input logic [DATA_W-1:0] load1,
    input logic [DATA_W-1:0] count0,
    input logic [DATA_W-1:0] count1
);
    // R8: interrupt is last edge's OR of enabled flags
    a_r8_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(flag_v & ie_v)));

    // R10: spare word reads zero
    a_r10_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr[3:2] == 2'd3) |-> bus_rdata == '0);

    // R10: absent window reads zero
    a_r10_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr[4] && TIMER_COUNT == 1) |-> bus_rdata == '0);

    // R3: restart loads the count from the load register
    a_r3_restart_t0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_v[0] && bus_wdata[CB_RUN]) |=> count0 == $past(load0));
    a_r3_restart_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_v[1] && bus_wdata[CB_RUN]) |=> count1 == $past(load1));

    // R11: an idle counter keeps its count
    a_r11_idle_t0: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_v[0] && !wr_ctrl_v[0]) |=> $stable(count0));
    a_r11_idle_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_v[1] && !wr_ctrl_v[1]) |=> $stable(count1));

    for (genvar g = 0; g < NT_MAX; g++) begin : g_chk
        // R5: a flag only rises from a running counter
        a_r5_flag_from_run: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_v[g]) |-> $past(run_v[g]));
        // R6: a flag only falls after a clearing control write
        a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_v[g]) |-> $past(wr_ctrl_v[g] && bus_wdata[CB_FLAG]));
    end
endmodule

bind dual_timer_periph dtp_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIMER_COUNT(TIMER_COUNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .wr_ctrl_v (wr_ctrl_v),
    .run_v     (run_v),
    .flag_v    (flag_v),
    .ie_v      ({ctrl_v[1][dtp_pkg::CB_IE], ctrl_v[0][dtp_pkg::CB_IE]}),
    .load0     (load_v[0]),
    .load1     (load_v[1]),
    .count0    (count_v[0]),
    .count1    (count_v[1])
);

// File: tb/dual_timer_periph_tb.sv
module dual_timer_periph_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata, rdata_s;
    logic        irq, irq_s;
    int vectors = 0;
    int fails = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    dual_timer_periph #(.TIMER_COUNT(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata), .irq_o(irq));

    dual_timer_periph #(.TIMER_COUNT(1)) u_dut_single (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .irq_o(irq_s));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write commits on the next posedge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_en = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic [31:0] ds);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #1;
        d = rdata; ds = rdata_s;
        bus_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, ds, held;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: everything reads zero after reset
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), d, ds);
            chk("R1 reset read", d, 0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 0);

        // R2: load readback, control width, count write ignored
        wr(5'h04, 32'hDEADBEEF);
        rd(5'h04, d, ds); chk("R2 load readback", d, 32'hDEADBEEF);
        wr(5'h00, 32'hFFFFFF7F);
        rd(5'h00, d, ds); chk("R2 ctrl 11 bits, flag not set", d, 32'h0000067F);
        wr(5'h00, 32'h0);
        wr(5'h08, 32'h1234);
        rd(5'h08, d, ds); chk("R2 count write ignored", d, 0);

        // R10: spare word
        wr(5'h0C, 32'hAA55AA55);
        rd(5'h0C, d, ds); chk("R10 spare word zero", d, 0);

        // R3: down sweep, no auto-restart (bit1 down, bit6 ie, bit7 run, bit8 clear)
        for (int L = 0; L < 8; L++) begin
            wr(5'h04, 32'(L));
            wr(5'h00, 32'h1C2);
            for (int m = 0; m <= L; m++) begin
                rd(5'h08, d, ds); chk("R3 down count", d, 32'(L - m));
                rd(5'h00, d, ds); chk("R3 flag not yet", {31'd0, d[8]}, 0);
                @(negedge clk);
            end
            rd(5'h00, d, ds); chk("R3 flag at L+1", {31'd0, d[8]}, 1);
            chk("R8 irq lags flag", {31'd0, irq}, 0);
            @(negedge clk);
            chk("R8 irq set", {31'd0, irq}, 1);
            repeat (3) @(negedge clk);
            rd(5'h08, d, ds); chk("R5 halted at zero", d, 0);
        end

        // R4: up sweep near all-ones
        for (int j = 0; j < 8; j++) begin
            wr(5'h04, 32'hFFFFFFFF - 32'(j));
            wr(5'h00, 32'h1C0);
            for (int m = 0; m <= j; m++) begin
                rd(5'h08, d, ds); chk("R4 up count", d, 32'hFFFFFFFF - 32'(j) + 32'(m));
                rd(5'h00, d, ds); chk("R4 flag not yet", {31'd0, d[8]}, 0);
                @(negedge clk);
            end
            rd(5'h00, d, ds); chk("R4 flag at 2^32-L", {31'd0, d[8]}, 1);
            repeat (2) @(negedge clk);
            rd(5'h08, d, ds); chk("R5 halted at all-ones", d, 32'hFFFFFFFF);
        end

        // R5: auto-restart period with load 2
        wr(5'h04, 32'd2);
        wr(5'h00, 32'h1D2);
        for (int m = 0; m < 9; m++) begin
            rd(5'h08, d, ds); chk("R5 reload sequence", d, 32'(2 - (m % 3)));
            @(negedge clk);
        end
        // now 9 edges after start: count 2, flag set
        rd(5'h00, d, ds); chk("R5 flag while reloading", {31'd0, d[8]}, 1);
        @(negedge clk); // count 1; next edge goes to 0, no expiry
        wr(5'h00, 32'h1D2);
        rd(5'h00, d, ds); chk("R6 write-1 clears flag", {31'd0, d[8]}, 0);
        repeat (3) @(negedge clk);
        rd(5'h00, d, ds); chk("R5 flag again", {31'd0, d[8]}, 1);
        @(negedge clk); // count 1 after a reload
        wr(5'h00, 32'h0D2);
        rd(5'h00, d, ds); chk("R6 write-0 keeps flag", {31'd0, d[8]}, 1);

        // R11: stop holds count
        wr(5'h04, 32'd100);
        wr(5'h00, 32'h1C2);
        repeat (5) @(negedge clk);
        wr(5'h00, 32'h042);
        rd(5'h08, held, ds); chk("R11 frozen on stop edge", held, 32'd95);
        repeat (10) @(negedge clk);
        rd(5'h08, d, ds); chk("R11 stays frozen", d, 32'd95);

        // R7: clear write on the expiry edge
        wr(5'h04, 32'd3);
        wr(5'h00, 32'h1C2);
        repeat (3) @(negedge clk);
        wr(5'h00, 32'h142);
        rd(5'h00, d, ds); chk("R7 expiry beats clear", {31'd0, d[8]}, 1);
        wr(5'h00, 32'h100);
        rd(5'h00, d, ds); chk("R6 cleared after", {31'd0, d[8]}, 0);

        // R8: masked flag raises no interrupt; enabling raises it one edge later
        wr(5'h04, 32'd1);
        wr(5'h00, 32'h182);
        repeat (4) @(negedge clk);
        rd(5'h00, d, ds); chk("R8 masked flag set", {31'd0, d[8]}, 1);
        chk("R8 masked irq low", {31'd0, irq}, 0);
        wr(5'h00, 32'h042);
        chk("R8 irq lags enable", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R8 irq after enable", {31'd0, irq}, 1);
        wr(5'h00, 32'h100);
        @(negedge clk);
        chk("R8 irq drops after clear", {31'd0, irq}, 0);

        // R9: second window at 0x10 runs on its own
        rd(5'h08, held, ds);
        wr(5'h14, 32'd4);
        wr(5'h10, 32'h1C2);
        for (int m = 0; m <= 4; m++) begin
            rd(5'h18, d, ds); chk("R9 timer1 count", d, 32'(4 - m));
            @(negedge clk);
        end
        rd(5'h10, d, ds); chk("R9 timer1 flag", {31'd0, d[8]}, 1);
        rd(5'h00, d, ds); chk("R9 timer0 flag untouched", {31'd0, d[8]}, 0);
        rd(5'h08, d, ds); chk("R9 timer0 count untouched", d, held);
        @(negedge clk);
        chk("R9 irq from timer1", {31'd0, irq}, 1);
        wr(5'h1C, 32'h5);
        rd(5'h1C, d, ds); chk("R10 timer1 spare zero", d, 0);

        // R10: single-counter build ignores the 0x10 window
        wr(5'h14, 32'h55);
        rd(5'h14, d, ds); chk("R10 single window load zero", ds, 0);
        wr(5'h10, 32'h1C2);
        repeat (3) @(negedge clk);
        rd(5'h10, d, ds); chk("R10 single window ctrl zero", ds, 0);
        chk("R10 single irq low", {31'd0, irq_s}, 0);
        wr(5'h04, 32'd9);
        rd(5'h04, d, ds); chk("R10 single timer0 works", ds, 32'd9);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule